// File: doc/BRIEF.md
# Serial Command Receiver With Inactivity Cancel

This block is the receive side of a byte-oriented serial port. It runs on a fast system clock. It samples three external lines through synchronizers: a serial clock, a data line and an active-low select. Bits are taken on each rising serial-clock edge while the select is low, most significant bit first. Every eight bits form a byte. Bytes are grouped into commands. Each command starts with one instruction byte, which gives the direction, the number of data bytes (one to four) and a register address. The data bytes follow the instruction byte.

Write data is gathered in a shadow buffer. It is handed to the register file through a one-cycle write strobe, and only after the last data byte of the command has arrived. A read command raises a one-cycle request carrying the address. The data-byte slots that follow a read are then consumed, and the incoming bits in them are discarded.

An inactivity watchdog guards every command that has been partly received. If neither the serial clock nor the select line changes for a set number of system clocks, the watchdog drops the partial byte and the command in progress, and it flags the cancellation. A write cancelled this way never produces a write strobe.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `reg_we`, `rd_req` and `cmd_abort` are low, and `reg_addr`, `reg_wdata` and `rd_addr` are zero.
- R2: A bit is captured on each rising serial-clock edge while the select is low, most significant bit first, and eight captured bits make one byte.
- R3: While `csn_in` is high, serial-clock edges capture no bits and do not advance the command framing.
- R4: A rising edge on `csn_in` discards any bits of a partly received byte, so the next captured bit starts a new byte.
- R5: The instruction byte is coded as: bit 7 gives the direction (0 = write, 1 = read), bits 6:5 give the data-byte count minus one, and bits 4:0 give the address. After the final data byte of a write, `reg_we` is high for exactly one cycle. With it, `reg_addr` carries the address and `reg_wdata` carries the data bytes in arrival order, right-aligned and zero-extended.
- R6: A read instruction pulses `rd_req` for one cycle with its address on `rd_addr`. The following count of bytes is consumed without any write strobe.
- R7: With `csn_in` held low throughout, commands follow one another without gaps. The byte after a command's last byte is taken as a new instruction.
- R8: When a command or a byte is partly received and no edge occurs on the serial clock or the select for `TIMEOUT_CYC` system clocks, `cmd_abort` pulses for one cycle.
- R9: A cancelled write never raises `reg_we`, and the byte received after a cancellation is treated as an instruction.
- R10: Any edge on the serial clock or the select restarts the inactivity window. Stalls shorter than the window, even when their total exceeds it, cause no cancellation.
- R11: With no byte or command partly received, the interface never signals a cancellation, however long it stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous serial clock |
| csn_in | input | 1 | Asynchronous active-low select |
| sdi_in | input | 1 | Asynchronous serial data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 5 | Write address |
| reg_wdata | output | 32 | Write data, right-aligned |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 5 | Read address |
| cmd_abort | output | 1 | One-cycle cancellation flag |

## Verification
The assertions assume that the serial lines change slowly compared with the system clock. In particular, every serial-clock level and every select level must last for several system clocks, so that each transition yields a single clean edge after the synchronizers. They also assume that the data line is stable for a few system clocks before each rising serial-clock edge. The stimulus meets these assumptions: every line is driven on falling system-clock edges, and each level is held for at least four system clocks. The bench uses a short inactivity window. Its stalls are kept either well under that window or well beyond it, never near the threshold.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int ADDR_W    = 5;
  localparam int LEN_W     = 2;
  localparam int MAX_BYTES = 1 << LEN_W;
  localparam int DATA_W    = 8 * MAX_BYTES;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_WDATA = 2'd1,
    FR_RSKIP = 2'd2
  } frame_st_t;

  // Instruction byte layout: direction, count-1, address.
  typedef struct packed {
    logic              is_read;
    logic [LEN_W-1:0]  len_m1;
    logic [ADDR_W-1:0] addr;
  } instr_t;
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level
);
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_ch
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], async_in[g]};
      end
      assign level[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_rise,
  input  logic       cs_sel,
  input  logic       cs_rise,
  input  logic       sdi,
  input  logic       clear,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic [2:0] bit_cnt
);
  logic [6:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (clear || cs_rise) begin
        bit_cnt <= '0;
      end else if (sclk_rise && cs_sel) begin
        shreg   <= {shreg[5:0], sdi};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {shreg, sdi};
        end
      end
    end
  end
endmodule

// File: rtl/serial_idle_timer.sv
module serial_idle_timer #(
  parameter int TIMEOUT_CYC = 250000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             activity,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!busy || activity) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt    <= '0;
        expire <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/serial_cmd_frame.sv
module serial_cmd_frame
  import serial_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              clear,
  output logic              busy,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);
  frame_st_t         state;
  logic [LEN_W-1:0]  rem;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] shadow;
  logic [DATA_W-1:0] shifted;
  instr_t            ins;

  assign ins     = instr_t'(byte_data);
  assign shifted = {shadow[DATA_W-9:0], byte_data};
  assign busy    = (state != FR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FR_IDLE;
      rem       <= '0;
      addr_q    <= '0;
      shadow    <= '0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
    end else begin
      reg_we <= 1'b0;
      rd_req <= 1'b0;
      if (clear) begin
        state <= FR_IDLE;
      end else if (byte_vld) begin
        unique case (state)
          FR_IDLE: begin
            addr_q <= ins.addr;
            rem    <= ins.len_m1;
            shadow <= '0;
            if (ins.is_read) begin
              rd_req  <= 1'b1;
              rd_addr <= ins.addr;
              state   <= FR_RSKIP;
            end else begin
              state <= FR_WDATA;
            end
          end
          FR_WDATA: begin
            shadow <= shifted;
            if (rem == '0) begin
              reg_we    <= 1'b1;
              reg_addr  <= addr_q;
              reg_wdata <= shifted;
              state     <= FR_IDLE;
            end else begin
              rem <= rem - LEN_W'(1);
            end
          end
          FR_RSKIP: begin
            if (rem == '0) state <= FR_IDLE;
            else           rem   <= rem - LEN_W'(1);
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              csn_in,
  input  logic              sdi_in,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_abort
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [2:0]       lvl;
  logic             sclk_prev, csn_prev;
  logic             sclk_rise, cs_rise, cs_sel, activity;
  logic             byte_vld;
  logic [7:0]       byte_data;
  logic [2:0]       bit_cnt;
  logic             frame_busy, busy, expire;
  logic [CNT_W-1:0] tmo_cnt;

  // Channel order: 0 serial clock, 1 select, 2 data.
  serial_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .async_in({sdi_in, csn_in, sclk_in}), .level(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      csn_prev  <= 1'b1;
    end else begin
      sclk_prev <= lvl[0];
      csn_prev  <= lvl[1];
    end
  end

  assign sclk_rise = lvl[0] & ~sclk_prev;
  assign cs_rise   = lvl[1] & ~csn_prev;
  assign cs_sel    = ~lvl[1];
  assign activity  = (lvl[0] ^ sclk_prev) | (lvl[1] ^ csn_prev);

  serial_byte_rx u_rx (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .cs_sel(cs_sel),
    .cs_rise(cs_rise), .sdi(lvl[2]), .clear(expire),
    .byte_vld(byte_vld), .byte_data(byte_data), .bit_cnt(bit_cnt)
  );

  serial_cmd_frame u_frame (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .clear(expire), .busy(frame_busy), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_req(rd_req), .rd_addr(rd_addr)
  );

  assign busy = (bit_cnt != 3'd0) | frame_busy;

  serial_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst(rst), .busy(busy), .activity(activity),
    .expire(expire), .cnt(tmo_cnt)
  );

  assign cmd_abort = expire;
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk #(
  parameter int TIMEOUT_CYC = 250000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic             rd_req,
  input logic             cmd_abort,
  input logic             byte_vld,
  input logic             cs_sel,
  input logic [CNT_W-1:0] tmo_cnt
);
  assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_read_no_commit_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !reg_we);

  assert_select_gate_R3: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> $past(cs_sel));

  assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |=> !cmd_abort);

  assert_abort_no_commit_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |-> !reg_we);

  assert_window_bound_R10: assert property (@(posedge clk) disable iff (rst)
    tmo_cnt < CNT_W'(TIMEOUT_CYC));
endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .rd_req(rd_req),
  .cmd_abort(cmd_abort), .byte_vld(byte_vld), .cs_sel(cs_sel),
  .tmo_cnt(tmo_cnt)
);

// File: tb/serial_cmd_rx_bench.sv
`timescale 1ns/1ps
module serial_cmd_rx_bench;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        csn = 1'b1;
  logic        sdi = 1'b0;
  logic        reg_we, rd_req, cmd_abort;
  logic [4:0]  reg_addr, rd_addr;
  logic [31:0] reg_wdata;

  int n_chk = 0;
  int n_bad = 0;
  int we_cnt = 0, rd_cnt = 0, ab_cnt = 0;
  logic [4:0]  last_addr = '0, last_rd = '0;
  logic [31:0] last_data = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_cmd_rx #(.TIMEOUT_CYC(TMO)) u_serial_cmd_rx (
    .clk(clk), .rst(rst), .sclk_in(sclk), .csn_in(csn), .sdi_in(sdi),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .cmd_abort(cmd_abort)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we)    begin we_cnt++; last_addr = reg_addr; last_data = reg_wdata; end
      if (rd_req)    begin rd_cnt++; last_rd = rd_addr; end
      if (cmd_abort) ab_cnt++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_bit(logic b);
    sdi = b; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic expect_write(string tag, int cnt0, logic [4:0] a, logic [31:0] d);
    tick(12);
    chk({tag, " write count"}, 32'(we_cnt), 32'(cnt0 + 1));
    chk({tag, " addr"}, {27'd0, last_addr}, {27'd0, a});
    chk({tag, " data"}, last_data, d);
  endtask

  task automatic t_reset();
    chk("R1 reg_we", {31'd0, reg_we}, 32'd0);
    chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
    chk("R1 cmd_abort", {31'd0, cmd_abort}, 32'd0);
    chk("R1 reg_wdata", reg_wdata, 32'd0);
    chk("R1 addrs", {22'd0, reg_addr, rd_addr}, 32'd0);
  endtask

  task automatic t_write_single();
    int c = we_cnt;
    put_byte(8'h05); put_byte(8'hA5);
    expect_write("R2 R5 single", c, 5'h05, 32'h0000_00A5);
  endtask

  task automatic t_write_four();
    int c = we_cnt;
    put_byte(8'h6A); put_byte(8'h12); put_byte(8'h34); put_byte(8'h56);
    tick(12);
    chk("R5 no early commit", 32'(we_cnt), 32'(c));
    put_byte(8'h78);
    expect_write("R5 four", c, 5'h0A, 32'h1234_5678);
  endtask

  task automatic t_msb_order();
    int c = we_cnt;
    put_byte(8'h23); put_byte(8'h80); put_byte(8'h01);
    expect_write("R2 msb order", c, 5'h03, 32'h0000_8001);
  endtask

  task automatic t_read();
    int c = we_cnt;
    int r = rd_cnt;
    put_byte(8'hA7);
    tick(12);
    chk("R6 rd_req count", 32'(rd_cnt), 32'(r + 1));
    chk("R6 rd_addr", {27'd0, last_rd}, 32'h7);
    put_byte(8'hFF); put_byte(8'hFF);
    tick(12);
    chk("R6 no commit on read", 32'(we_cnt), 32'(c));
    put_byte(8'h01); put_byte(8'h3C);
    expect_write("R7 back to back", c, 5'h01, 32'h0000_003C);
  endtask

  task automatic t_cs_ignore();
    int c = we_cnt;
    csn = 1'b1; tick(8);
    put_byte(8'hFF);
    tick(8); csn = 1'b0; tick(8);
    put_byte(8'h02); put_byte(8'h5A);
    expect_write("R3 deselected clocks ignored", c, 5'h02, 32'h0000_005A);
  endtask

  task automatic t_cs_clear();
    int c = we_cnt;
    put_byte(8'h04);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    tick(4); csn = 1'b1; tick(8); csn = 1'b0; tick(8);
    put_byte(8'h3C);
    expect_write("R4 partial byte dropped", c, 5'h04, 32'h0000_003C);
  endtask

  task automatic t_abort_cmd();
    int c = we_cnt;
    int a = ab_cnt;
    put_byte(8'h6B); put_byte(8'h11); put_byte(8'h22);
    tick(150);
    chk("R8 abort after stalled command", 32'(ab_cnt), 32'(a + 1));
    chk("R9 no commit from cancelled write", 32'(we_cnt), 32'(c));
    put_byte(8'h01); put_byte(8'h77);
    expect_write("R9 instruction after cancel", c, 5'h01, 32'h0000_0077);
  endtask

  task automatic t_abort_bits();
    int c = we_cnt;
    int a = ab_cnt;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    tick(150);
    chk("R8 abort after partial byte", 32'(ab_cnt), 32'(a + 1));
    put_byte(8'h02); put_byte(8'hE1);
    expect_write("R9 clean byte after cancel", c, 5'h02, 32'h0000_00E1);
  endtask

  task automatic t_restart_cs();
    int c = we_cnt;
    int a = ab_cnt;
    put_byte(8'h09);
    tick(40); csn = 1'b1; tick(8); csn = 1'b0; tick(40);
    put_byte(8'hC3);
    expect_write("R10 select edge restarts window", c, 5'h09, 32'h0000_00C3);
    chk("R10 no abort (select)", 32'(ab_cnt), 32'(a));
  endtask

  task automatic t_restart_sclk();
    int c = we_cnt;
    int a = ab_cnt;
    put_byte(8'h0E);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    tick(50);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    expect_write("R10 clock edge restarts window", c, 5'h0E, 32'h0000_00A6);
    chk("R10 no abort (clock)", 32'(ab_cnt), 32'(a));
  endtask

  task automatic t_idle();
    int a = ab_cnt;
    tick(300);
    chk("R11 idle never aborts", 32'(ab_cnt), 32'(a));
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    t_reset();
    csn = 1'b0; tick(8);
    t_write_single();
    t_write_four();
    t_msb_order();
    t_read();
    t_cs_ignore();
    t_cs_clear();
    t_abort_cmd();
    t_abort_bits();
    t_restart_cs();
    t_restart_sclk();
    t_idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule